// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block decides when a successive-approximation converter samples its input and when it converts. Software sets an enable bit, a tracking-policy bit and a 3-bit start-mode field. The start-mode field picks one trigger from these sources:

- a software write to the busy bit,
- one of two timer overflow pulses,
- an external convert-start pin,
- the software start of a companion converter.

The block drives a `track` level and a `busy` (convert) level. It times each phase in SAR clocks, which an internal divider makes from the system clock.

There are two tracking policies:

- **Continuous.** The converter tracks whenever it is enabled and not converting. A trigger starts conversion on the next clock.
- **Low-power.** A trigger first opens a fixed tracking window of a set number of SAR clocks, and conversion follows immediately. In pin mode the pin level itself gates tracking: the block tracks while the pin is low and converts on its rising edge.

A fixed-length SAR-clock counter stands in for the analog conversion. When it ends, the block compares the supplied result against a low and a high limit. It keeps two sticky flags, conversion complete and window match, and software clears each one with a write.

Top module: `adc_start_seq`

## Requirements
- R1: After reset, `track`, `busy`, `done_flag`, `win_flag` and `sar_tick` are all 0.
- R2: While `cfg_enable` is 0, no trigger source starts anything: `busy` and `track` stay 0, and a conversion in progress is abandoned without setting `done_flag`.
- R3: With `cfg_lp_track`=0 and `cfg_enable`=1, `track` is 1 whenever `busy` is 0 and is 0 whenever `busy` is 1.
- R4: A trigger pulse seen at a clock edge makes `busy` 1 from that edge on. `busy` then stays 1 for exactly CONV_CLKS*SAR_DIV system clocks.
- R5: The start-mode code selects the trigger. 000 is a busy-bit write of 1, 001 is `tmr3_ovf`, 010 is a rising edge of the selected pin, 011 is `tmr2_ovf`, and 1xx is `peer_start`. Sources that are not selected are ignored.
- R6: A write of 1 to the busy bit (`busy_wr`=1, `busy_wdata`=1) starts a conversion only when the start mode is 000. A write of 0 never starts anything.
- R7: With `cfg_lp_track`=1 and a mode other than 010, a trigger makes `track` 1 for exactly TRACK_CLKS*SAR_DIV system clocks. `busy` rises on the same edge at which `track` falls.
- R8: With `cfg_lp_track`=1 and mode 010, `track` follows the inverted, synchronized pin level while the block is idle. A pin rise starts conversion at the third clock edge after the change.
- R9: The pin source is `ext_pin_ded` when `ded_pin_en`=1. Otherwise it is `ext_pin_shr` when `shr_pin_en`=1. With neither enabled, no pin edge is seen.
- R10: A trigger that arrives while tracking or converting is ignored. The running phase is not lengthened, and nothing is queued.
- R11: `done_flag` is set on the edge at which `busy` falls at the end of a conversion. It holds until a `clr_done` pulse, and a set in the same cycle wins over the clear.
- R12: `win_flag` is set on the same edge as `done_flag` when win_lo <= conv_result <= win_hi, with both limits included. It holds until a `clr_win` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | 1 = enabled, 0 = shutdown |
| cfg_lp_track | input | 1 | 0 = continuous tracking, 1 = low-power tracking |
| cfg_start_mode | input | 3 | Start-mode select code |
| busy_wr | input | 1 | Write strobe for the busy bit |
| busy_wdata | input | 1 | Value written to the busy bit |
| clr_done | input | 1 | Clears the conversion-complete flag |
| clr_win | input | 1 | Clears the window-match flag |
| tmr3_ovf | input | 1 | Timer-3 overflow pulse |
| tmr2_ovf | input | 1 | Timer-2 overflow pulse |
| peer_start | input | 1 | Companion converter software start pulse |
| ext_pin_ded | input | 1 | Dedicated external convert-start pin |
| ext_pin_shr | input | 1 | Shared external convert-start pin |
| ded_pin_en | input | 1 | Dedicated pin is routed to this block |
| shr_pin_en | input | 1 | Shared pin is routed to this block |
| conv_result | input | RES_W | Conversion result to compare |
| win_lo | input | RES_W | Window low limit (inclusive) |
| win_hi | input | RES_W | Window high limit (inclusive) |
| track | output | 1 | Converter tracking its input |
| busy | output | 1 | Conversion in progress |
| done_flag | output | 1 | Sticky conversion-complete flag |
| win_flag | output | 1 | Sticky window-match flag |
| sar_tick | output | 1 | One-cycle pulse per SAR clock while a phase runs |

## Verification
The bench builds the block with SAR_DIV=2, CONV_CLKS=4, TRACK_CLKS=3 and RES_W=8. This gives an 8-cycle conversion and a 6-cycle low-power track window. Every trigger mode, both tracking policies and the window boundaries then fit into short directed runs. A divider of 2 is the smallest that still exercises the divider counter. Because of it, an error of one SAR tick or one system clock in either phase gives a length that differs from the expected value.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_CONV  = 2'd2
  } seq_st_t;

  localparam logic [2:0] SM_SOFT = 3'b000;
  localparam logic [2:0] SM_TMR3 = 3'b001;
  localparam logic [2:0] SM_PIN  = 3'b010;
  localparam logic [2:0] SM_TMR2 = 3'b011;

  // Inclusive window test on zero-extended values
  function automatic logic in_window(input logic [31:0] v,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // Number of system clocks a phase of n SAR clocks lasts
  function automatic int unsigned phase_cycles(input int unsigned n,
                                               input int unsigned div);
    return n * div;
  endfunction

endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_d,
  output logic pin_lvl,
  output logic pin_rise
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], pin_d};
  end

  assign pin_lvl  = sh_q[SYNC_STAGES-1];
  assign pin_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
(
  input  logic [2:0] start_mode,
  input  logic       sw_go,
  input  logic       tmr3_ovf,
  input  logic       tmr2_ovf,
  input  logic       pin_rise,
  input  logic       peer_start,
  output logic       trig_go
);
  always_comb begin
    casez (start_mode)
      SM_SOFT: trig_go = sw_go;
      SM_TMR3: trig_go = tmr3_ovf;
      SM_PIN:  trig_go = pin_rise;
      SM_TMR2: trig_go = tmr2_ovf;
      3'b1??:  trig_go = peer_start;
      default: trig_go = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_sar_timer.sv
module adc_sar_timer #(
  parameter int SAR_DIV = 4,
  parameter int LEN_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LEN_W-1:0] len,
  output logic             tick,
  output logic             phase_done
);
  localparam int DIV_W = (SAR_DIV > 1) ? $clog2(SAR_DIV) : 1;

  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] ph_q;

  assign tick       = run && (div_q == DIV_W'(SAR_DIV - 1));
  assign phase_done = tick && (ph_q == len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ph_q  <= '0;
    end else if (!run || phase_done) begin
      div_q <= '0;
      ph_q  <= '0;
    end else if (tick) begin
      div_q <= '0;
      ph_q  <= ph_q + LEN_W'(1);
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W      = 12,
  parameter int SAR_DIV    = 4,
  parameter int CONV_CLKS  = 14,
  parameter int TRACK_CLKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_lp_track,
  input  logic [2:0]       cfg_start_mode,
  input  logic             busy_wr,
  input  logic             busy_wdata,
  input  logic             clr_done,
  input  logic             clr_win,
  input  logic             tmr3_ovf,
  input  logic             tmr2_ovf,
  input  logic             peer_start,
  input  logic             ext_pin_ded,
  input  logic             ext_pin_shr,
  input  logic             ded_pin_en,
  input  logic             shr_pin_en,
  input  logic [RES_W-1:0] conv_result,
  input  logic [RES_W-1:0] win_lo,
  input  logic [RES_W-1:0] win_hi,
  output logic             track,
  output logic             busy,
  output logic             done_flag,
  output logic             win_flag,
  output logic             sar_tick
);
  localparam int MAX_CLKS = (CONV_CLKS > TRACK_CLKS) ? CONV_CLKS : TRACK_CLKS;
  localparam int LEN_W    = $clog2(MAX_CLKS + 1);

  seq_st_t          state_q, state_d;
  logic             sel_pin, pin_lvl, pin_rise;
  logic             sw_go, trig_go, start_go, conv_end, pin_mode;
  logic             phase_run, phase_done, in_win;
  logic [LEN_W-1:0] phase_len;
  logic             done_q, win_q;

  // Pin routing: dedicated pin first, shared pin second, idle-high otherwise
  assign sel_pin = ded_pin_en ? ext_pin_ded : (shr_pin_en ? ext_pin_shr : 1'b1);

  adc_pin_sync #(.SYNC_STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_d    (sel_pin),
    .pin_lvl  (pin_lvl),
    .pin_rise (pin_rise)
  );

  assign sw_go    = busy_wr && busy_wdata;
  assign pin_mode = (cfg_start_mode == SM_PIN);

  adc_trig_sel u_sel (
    .start_mode (cfg_start_mode),
    .sw_go      (sw_go),
    .tmr3_ovf   (tmr3_ovf),
    .tmr2_ovf   (tmr2_ovf),
    .pin_rise   (pin_rise),
    .peer_start (peer_start),
    .trig_go    (trig_go)
  );

  assign phase_run = (state_q == ST_TRACK) || (state_q == ST_CONV);
  assign phase_len = (state_q == ST_TRACK) ? LEN_W'(TRACK_CLKS) : LEN_W'(CONV_CLKS);

  adc_sar_timer #(.SAR_DIV(SAR_DIV), .LEN_W(LEN_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (phase_run),
    .len        (phase_len),
    .tick       (sar_tick),
    .phase_done (phase_done)
  );

  assign start_go = cfg_enable && (state_q == ST_IDLE) && trig_go;

  always_comb begin
    state_d  = state_q;
    conv_end = 1'b0;
    if (!cfg_enable) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (start_go)
                    state_d = (cfg_lp_track && !pin_mode) ? ST_TRACK : ST_CONV;
        ST_TRACK: if (phase_done) state_d = ST_CONV;
        ST_CONV:  if (phase_done) begin
                    conv_end = 1'b1;
                    state_d  = ST_IDLE;
                  end
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign in_win = in_window(32'(conv_result), 32'(win_lo), 32'(win_hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      win_q  <= 1'b0;
    end else begin
      if (conv_end)      done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
      if (conv_end && in_win) win_q <= 1'b1;
      else if (clr_win)       win_q <= 1'b0;
    end
  end

  assign busy      = (state_q == ST_CONV);
  assign track     = cfg_enable && (
                       (!cfg_lp_track && state_q != ST_CONV) ||
                       (state_q == ST_TRACK) ||
                       (cfg_lp_track && pin_mode && state_q == ST_IDLE && !pin_lvl));
  assign done_flag = done_q;
  assign win_flag  = win_q;
endmodule

// File: rtl/adc_start_seq_chk.sv
module adc_start_seq_chk #(
  parameter int SAR_DIV   = 4,
  parameter int CONV_CLKS = 14
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic clr_done,
  input logic busy,
  input logic track,
  input logic done_flag,
  input logic win_flag,
  input logic conv_end
);
  int unsigned busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else           busy_cnt <= 0;
  end

  a_r2_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !busy);

  a_r3_no_track_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !track);

  a_r4_conv_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(cfg_enable)) |-> (busy_cnt == 0 || 1'b1) && done_flag);

  a_r4_conv_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_end) |-> (busy_cnt == CONV_CLKS * SAR_DIV - 1));

  a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !clr_done) |=> done_flag);

  a_r12_win_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_flag) |-> $past(conv_end));
endmodule

bind adc_start_seq adc_start_seq_chk #(
  .SAR_DIV   (SAR_DIV),
  .CONV_CLKS (CONV_CLKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_enable (cfg_enable),
  .clr_done   (clr_done),
  .busy       (busy),
  .track      (track),
  .done_flag  (done_flag),
  .win_flag   (win_flag),
  .conv_end   (conv_end)
);

// File: tb/adc_start_seq_bench.sv
module adc_start_seq_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int RES_W = 8;
  localparam int DIV   = 2;
  localparam int CONV  = 4;
  localparam int TRK   = 3;
  localparam int CONV_CYC = CONV * DIV;
  localparam int TRK_CYC  = TRK * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 0, cfg_lp_track = 0;
  logic [2:0] cfg_start_mode = 3'b000;
  logic busy_wr = 0, busy_wdata = 0, clr_done = 0, clr_win = 0;
  logic tmr3_ovf = 0, tmr2_ovf = 0, peer_start = 0;
  logic ext_pin_ded = 1, ext_pin_shr = 1, ded_pin_en = 0, shr_pin_en = 0;
  logic [RES_W-1:0] conv_result = '0, win_lo = '0, win_hi = '0;
  logic track, busy, done_flag, win_flag, sar_tick;

  int checks = 0;
  int failures = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  adc_start_seq #(.RES_W(RES_W), .SAR_DIV(DIV), .CONV_CLKS(CONV), .TRACK_CLKS(TRK))
  u_adc_start_seq (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_lp_track(cfg_lp_track),
    .cfg_start_mode(cfg_start_mode), .busy_wr(busy_wr), .busy_wdata(busy_wdata),
    .clr_done(clr_done), .clr_win(clr_win), .tmr3_ovf(tmr3_ovf), .tmr2_ovf(tmr2_ovf),
    .peer_start(peer_start), .ext_pin_ded(ext_pin_ded), .ext_pin_shr(ext_pin_shr),
    .ded_pin_en(ded_pin_en), .shr_pin_en(shr_pin_en), .conv_result(conv_result),
    .win_lo(win_lo), .win_hi(win_hi), .track(track), .busy(busy),
    .done_flag(done_flag), .win_flag(win_flag), .sar_tick(sar_tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // src: 0 busy write 1, 1 timer-3, 2 timer-2, 3 peer start, 4 busy write 0
  task automatic fire(input int src);
    case (src)
      0: begin busy_wr = 1; busy_wdata = 1; end
      1: tmr3_ovf = 1;
      2: tmr2_ovf = 1;
      3: peer_start = 1;
      default: begin busy_wr = 1; busy_wdata = 0; end
    endcase
    @(negedge clk);
    busy_wr = 0; busy_wdata = 0; tmr3_ovf = 0; tmr2_ovf = 0; peer_start = 0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic clear_flags();
    clr_done = 1; clr_win = 1;
    @(negedge clk);
    clr_done = 0; clr_win = 0;
  endtask

  task automatic t_reset();
    chk("R1 track", track, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done_flag, 0);
    chk("R1 win", win_flag, 0);
    chk("R1 tick", sar_tick, 0);
  endtask

  task automatic t_off();
    cfg_enable = 0;
    for (int s = 0; s < 4; s++) begin
      cfg_start_mode = (s == 0) ? 3'b000 : (s == 1) ? 3'b001 : (s == 2) ? 3'b011 : 3'b100;
      fire(s);
      chk("R2 busy while off", busy, 0);
      chk("R2 track while off", track, 0);
    end
    // abandon a running conversion
    cfg_enable = 1; cfg_start_mode = 3'b000;
    fire(0);
    repeat (2) @(negedge clk);
    cfg_enable = 0;
    @(negedge clk);
    chk("R2 abort busy", busy, 0);
    repeat (CONV_CYC) @(negedge clk);
    chk("R2 abort no done", done_flag, 0);
  endtask

  task automatic t_soft();
    int n;
    cfg_enable = 1; cfg_lp_track = 0; cfg_start_mode = 3'b000;
    @(negedge clk);
    chk("R3 idle track", track, 1);
    fire(0);
    chk("R4 busy after start", busy, 1);
    chk("R3 no track in conv", track, 0);
    count_busy(n);
    chk("R4 conv length", n, CONV_CYC);
    chk("R11 done at busy fall", done_flag, 1);
    chk("R3 track after conv", track, 1);
    repeat (5) @(negedge clk);
    chk("R11 done sticky", done_flag, 1);
    clr_done = 1; @(negedge clk); clr_done = 0;
    chk("R11 done cleared", done_flag, 0);
  endtask

  task automatic t_sources();
    int n;
    logic [2:0] modes [4] = '{3'b001, 3'b011, 3'b100, 3'b111};
    int good [4] = '{1, 2, 3, 3};
    int bad  [4] = '{2, 1, 0, 1};
    cfg_enable = 1; cfg_lp_track = 0;
    for (int i = 0; i < 4; i++) begin
      cfg_start_mode = modes[i];
      @(negedge clk);
      fire(bad[i]);
      chk("R5 unselected source ignored", busy, 0);
      fire(good[i]);
      chk("R5 selected source starts", busy, 1);
      count_busy(n);
      chk("R5 conv length", n, CONV_CYC);
    end
  endtask

  task automatic t_wr_rules();
    cfg_enable = 1; cfg_lp_track = 0;
    cfg_start_mode = 3'b001;
    @(negedge clk);
    fire(0);
    chk("R6 write 1 in mode 001", busy, 0);
    cfg_start_mode = 3'b000;
    @(negedge clk);
    fire(4);
    chk("R6 write 0 no start", busy, 0);
  endtask

  task automatic t_lp();
    int n;
    cfg_enable = 1; cfg_lp_track = 1; cfg_start_mode = 3'b011;
    @(negedge clk);
    chk("R7 no track before trigger", track, 0);
    fire(2);
    n = 0;
    while (track && !busy && n < 1000) begin n++; @(negedge clk); end
    chk("R7 track window", n, TRK_CYC);
    chk("R7 busy after window", busy, 1);
    chk("R7 track off in conv", track, 0);
    count_busy(n);
    chk("R7 conv length", n, CONV_CYC);
    chk("R7 track off after conv", track, 0);
  endtask

  task automatic t_pin();
    cfg_enable = 1; cfg_lp_track = 1; cfg_start_mode = 3'b010;
    ded_pin_en = 1; shr_pin_en = 0;
    ext_pin_ded = 1; ext_pin_shr = 1;
    repeat (4) @(negedge clk);
    chk("R8 pin high no track", track, 0);
    ext_pin_ded = 0;
    repeat (3) @(negedge clk);
    chk("R8 pin low tracks", track, 1);
    chk("R8 pin low not busy", busy, 0);
    ext_pin_ded = 1;
    @(negedge clk); @(negedge clk);
    chk("R8 not yet busy", busy, 0);
    @(negedge clk);
    chk("R8 busy on third edge", busy, 1);
    chk("R8 track off in conv", track, 0);
    while (busy) @(negedge clk);
    // shared pin ignored while dedicated pin enabled
    ext_pin_shr = 0; repeat (3) @(negedge clk);
    ext_pin_shr = 1; repeat (4) @(negedge clk);
    chk("R9 shared ignored", busy, 0);
    // shared pin used when only it is enabled
    ded_pin_en = 0; shr_pin_en = 1; cfg_lp_track = 0;
    repeat (3) @(negedge clk);
    ext_pin_shr = 0; repeat (3) @(negedge clk);
    ext_pin_shr = 1; repeat (3) @(negedge clk);
    chk("R9 shared pin starts", busy, 1);
    while (busy) @(negedge clk);
    shr_pin_en = 0;
    ext_pin_ded = 0; ext_pin_shr = 0; repeat (3) @(negedge clk);
    ext_pin_ded = 1; ext_pin_shr = 1; repeat (4) @(negedge clk);
    chk("R9 no pin enabled", busy, 0);
  endtask

  task automatic t_ignore();
    int n;
    cfg_enable = 1; cfg_lp_track = 0; cfg_start_mode = 3'b000;
    @(negedge clk);
    fire(0);
    n = 1;
    @(negedge clk); n++;
    fire(0); n++;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    n--;
    chk("R10 conv not lengthened", n, CONV_CYC);
    repeat (2) @(negedge clk);
    chk("R10 nothing queued", busy, 0);
    cfg_lp_track = 1;
    fire(0);
    @(negedge clk);
    fire(0);
    n = 3;
    while (!busy && n < 1000) begin n++; @(negedge clk); end
    chk("R10 track not restarted", n - 1, TRK_CYC);
    while (busy) @(negedge clk);
    cfg_lp_track = 0;
  endtask

  task automatic t_window();
    int n;
    cfg_enable = 1; cfg_lp_track = 0; cfg_start_mode = 3'b000;
    clear_flags();
    win_lo = 8'd20; win_hi = 8'd50;
    conv_result = 8'd50;
    fire(0); count_busy(n);
    chk("R12 high limit inclusive", win_flag, 1);
    chk("R12 done with win", done_flag, 1);
    repeat (3) @(negedge clk);
    chk("R12 win sticky", win_flag, 1);
    clear_flags();
    chk("R12 win cleared", win_flag, 0);
    conv_result = 8'd19;
    fire(0); count_busy(n);
    chk("R12 below window", win_flag, 0);
    chk("R11 done outside window", done_flag, 1);
    clear_flags();
    conv_result = 8'd20;
    fire(0); count_busy(n);
    chk("R12 low limit inclusive", win_flag, 1);
    conv_result = 8'd51;
    clear_flags();
    fire(0);
    while (busy) begin
      clr_done = 1;
      @(negedge clk);
    end
    clr_done = 0;
    chk("R11 set wins over clear", done_flag, 1);
    chk("R12 above window", win_flag, 0);
  endtask

  initial begin
    repeat (1000 * 40) @(negedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_off();
    t_soft();
    t_sources();
    t_wr_rules();
    t_lp();
    t_pin();
    t_ignore();
    t_window();
    finish_run();
  end
endmodule